// File: doc/BRIEF.md
# Two-Side Ownership Lock

This block is a 2-bit lock register shared by two bus agents: a "master" side and a "control" side. Each side writes through its own request port. Both sides read the same stored value. Arbitration logic decides whether each write may change the stored code. The block also reports which side currently owns the guarded resource.

Two stored codes mean "free": `00` and `11`. The code `10` means the master side holds the lock, and the code `01` means the control side holds it. A side may store only its own claim code, and only while the lock is free. Only the current holder may free the lock, by writing `00` or `11`.

When a side writes its own claim code and the write is refused, that side's reject flag pulses for one cycle. When both sides write in the same cycle, the master side's write is evaluated first. The control side's write takes effect only if the master side's write was refused or was not a valid write.

Top module: `dual_owner_lock`

## Requirements
- R1: After reset the stored code is `00`, the owner output is 0 and both reject flags are low.
- R2: A master-side write of `10` while the stored code is `00` or `11` stores `10` at the next clock edge.
- R3: A control-side write of `01` while the stored code is `00` or `11` stores `01` at the next clock edge.
- R4: A claim write of a side's own code (`10` from the master side, `01` from the control side) while the stored code is `01` or `10` leaves the code unchanged. That side's reject flag is high for the cycle after the write.
- R5: The holding side writing `00` or `11` stores exactly the written code.
- R6: A write of `00` or `11` by the side that does not hold the lock leaves the code unchanged and raises no reject flag.
- R7: A side writing the other side's claim code (master writing `01`, control writing `10`) has no effect and raises no reject flag.
- R8: If both sides write their claim codes in the same cycle while the lock is free, the stored code becomes `10` and the control reject flag pulses.
- R9: A reject flag is high only in the cycle directly after a refused claim. It is low in any cycle that follows a cycle without a refused claim.
- R10: The owner output is decoded from the stored code: 0 (none) for `00` or `11`, 1 (master) for `10`, and 2 (control) for `01`.
- R11: When both sides make accepted-looking writes in one cycle, only the master side's write applies. This covers two cases: both sides writing free codes while the lock is free, and a master release at the same time as a control claim. In the second case the control claim is evaluated against the code as it was before the edge, so it is refused while the master holds the lock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mstWrEn | input | 1 | Master-side write strobe |
| mstWrData | input | 2 | Master-side write value |
| ctlWrEn | input | 1 | Control-side write strobe |
| ctlWrData | input | 2 | Control-side write value |
| lockCode | output | 2 | Stored lock code, readable by both sides |
| owner | output | 2 | Current holder: 0 none, 1 master, 2 control |
| mstReject | output | 1 | One-cycle pulse after a refused master claim |
| ctlReject | output | 1 | One-cycle pulse after a refused control claim |

## Verification
A corrupted stored code shows on `lockCode` and `owner` in the very next cycle. Every later claim or release then becomes accepted or refused in a way that does not match the expected sequence. A wrong priority or a wrong free test shows as a reject pulse in the cycle after the write, or as a missing pulse. Stepping through every legal and illegal transition from both free codes exposes such a fault within one cycle of the write that triggers it.

// File: rtl/lock_pkg.sv
package lock_pkg;
  localparam int CODE_W = 2;
  typedef logic [CODE_W-1:0] lockCode_t;

  localparam lockCode_t CODE_FREE_LO = 2'b00;
  localparam lockCode_t CODE_FREE_HI = 2'b11;
  localparam lockCode_t CODE_MST     = 2'b10;
  localparam lockCode_t CODE_CTL     = 2'b01;

  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_MST  = 2'd1,
    OWN_CTL  = 2'd2
  } owner_e;

  // strobes from control to datapath
  typedef struct packed {
    logic      loadEn;
    lockCode_t loadVal;
    logic      mstRej;
    logic      ctlRej;
  } lockCmd_t;

  function automatic logic isFree(lockCode_t c);
    return (c == CODE_FREE_LO) || (c == CODE_FREE_HI);
  endfunction
endpackage

// File: rtl/lock_ctrl.sv
module lock_ctrl
  import lock_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      mstWrEn,
  input  lockCode_t mstWrData,
  input  logic      ctlWrEn,
  input  lockCode_t ctlWrData,
  input  lockCode_t curVal,
  output lockCmd_t  cmd
);
  logic curFree;
  logic mstClaim, mstRel, ctlClaim, ctlRel;
  logic mstOk, ctlOk;

  always_comb begin
    curFree  = isFree(curVal);
    mstClaim = mstWrEn && (mstWrData == CODE_MST);
    mstRel   = mstWrEn && isFree(mstWrData);
    ctlClaim = ctlWrEn && (ctlWrData == CODE_CTL);
    ctlRel   = ctlWrEn && isFree(ctlWrData);

    mstOk = (mstClaim && curFree) || (mstRel && (curFree || curVal == CODE_MST));
    ctlOk = (ctlClaim && curFree) || (ctlRel && (curFree || curVal == CODE_CTL));

    cmd.loadEn  = mstOk || ctlOk;
    cmd.loadVal = mstOk ? mstWrData : ctlWrData;
    cmd.mstRej  = mstClaim && !curFree;
    cmd.ctlRej  = ctlClaim && (!curFree || mstOk);
  end

  AST_MST_HOLD_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (curVal == CODE_MST && !mstWrEn) |=> curVal == CODE_MST); // R6
  AST_CTL_HOLD_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (curVal == CODE_CTL && !ctlWrEn) |=> curVal == CODE_CTL); // R6
  AST_TIE_MST_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (isFree(curVal) && mstWrEn && mstWrData == CODE_MST && ctlWrEn && ctlWrData == CODE_CTL)
      |=> curVal == CODE_MST); // R8
  AST_FOREIGN_CODE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (mstWrEn && mstWrData == CODE_CTL && !ctlWrEn) |=> $stable(curVal)); // R7
endmodule

// File: rtl/lock_data.sv
module lock_data
  import lock_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  lockCmd_t  cmd,
  output lockCode_t curVal,
  output owner_e    owner,
  output logic      mstReject,
  output logic      ctlReject
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curVal    <= CODE_FREE_LO;
      mstReject <= 1'b0;
      ctlReject <= 1'b0;
    end else begin
      if (cmd.loadEn) curVal <= cmd.loadVal;
      mstReject <= cmd.mstRej;
      ctlReject <= cmd.ctlRej;
    end
  end

  always_comb begin
    unique case (curVal)
      CODE_MST: owner = OWN_MST;
      CODE_CTL: owner = OWN_CTL;
      default:  owner = OWN_NONE;
    endcase
  end

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.loadEn |=> $stable(curVal)); // R4
  AST_NO_DIRECT_HANDOVER: assert property (@(posedge clk) disable iff (!rstN)
    (curVal == CODE_MST) |=> curVal != CODE_CTL); // R4
endmodule

// File: rtl/dual_owner_lock.sv
module dual_owner_lock
  import lock_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       mstWrEn,
  input  logic [1:0] mstWrData,
  input  logic       ctlWrEn,
  input  logic [1:0] ctlWrData,
  output logic [1:0] lockCode,
  output logic [1:0] owner,
  output logic       mstReject,
  output logic       ctlReject
);
  lockCmd_t  cmd;
  lockCode_t curVal;
  owner_e    ownerE;

  lock_ctrl uCtrl (
    .clk(clk), .rstN(rstN),
    .mstWrEn(mstWrEn), .mstWrData(mstWrData),
    .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .curVal(curVal), .cmd(cmd)
  );

  lock_data uData (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .curVal(curVal), .owner(ownerE),
    .mstReject(mstReject), .ctlReject(ctlReject)
  );

  assign lockCode = curVal;
  assign owner    = ownerE;
endmodule

// File: tb/tb_dual_owner_lock.sv
module tb_dual_owner_lock;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 23;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mstWrEn = 1'b0, ctlWrEn = 1'b0;
  logic [1:0] mstWrData = 2'b00, ctlWrData = 2'b00;
  logic [1:0] lockCode, owner;
  logic mstReject, ctlReject;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_owner_lock dut (
    .clk(clk), .rstN(rstN),
    .mstWrEn(mstWrEn), .mstWrData(mstWrData),
    .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .lockCode(lockCode), .owner(owner),
    .mstReject(mstReject), .ctlReject(ctlReject)
  );

  // fields: mEn mD cEn cD | expCode expOwner expMRej expCRej | req
  localparam logic [15:0] VEC [NVEC] = '{
    16'b1_10_0_00_10_01_0_0_0010, // R2 master claim from 00
    16'b0_00_1_01_10_01_0_1_0100, // R4 control claim blocked
    16'b0_00_1_00_10_01_0_0_0110, // R6 control cross-release 00
    16'b0_00_1_11_10_01_0_0_0110, // R6 control cross-release 11
    16'b1_01_0_00_10_01_0_0_0111, // R7 master writes control code
    16'b1_11_0_00_11_00_0_0_0101, // R5 master release to 11
    16'b0_00_1_01_01_10_0_0_0011, // R3 control claim from 11
    16'b1_10_0_00_01_10_1_0_0100, // R4 master claim blocked
    16'b1_00_0_00_01_10_0_0_0110, // R6 master cross-release
    16'b0_00_1_10_01_10_0_0_0111, // R7 control writes master code
    16'b0_00_1_00_00_00_0_0_0101, // R5 control release to 00
    16'b0_00_1_01_01_10_0_0_0011, // R3 control claim from 00
    16'b0_00_1_11_11_00_0_0_0101, // R5 control release to 11
    16'b1_10_0_00_10_01_0_0_0010, // R2 master claim from 11
    16'b1_00_0_00_00_00_0_0_0101, // R5 master release to 00
    16'b1_10_1_01_10_01_0_1_1000, // R8 simultaneous claims
    16'b1_00_1_01_00_00_0_1_1011, // R11 release plus claim same cycle
    16'b0_00_0_00_00_00_0_0_1001, // R9 strobe gone after idle
    16'b1_11_1_00_11_00_0_0_1011, // R11 both free codes, master applies
    16'b0_00_1_00_00_00_0_0_1011, // R11 free re-encode by control
    16'b1_01_1_01_01_10_0_0_0111, // R7 master foreign code, control claims
    16'b1_10_1_01_01_10_1_1_0100, // R4 both blocked while control holds
    16'b0_00_0_00_01_10_0_0_1001  // R9 strobes gone after idle
  };

  task automatic check(input string tag, input logic [1:0] expCode,
                       input logic [1:0] expOwn, input logic expM, input logic expC);
    total++;
    if (lockCode !== expCode || owner !== expOwn ||
        mstReject !== expM || ctlReject !== expC) begin
      bad++;
      $display("FAIL %s: code=%b owner=%0d mRej=%b cRej=%b expected code=%b owner=%0d mRej=%b cRej=%b",
               tag, lockCode, owner, mstReject, ctlReject, expCode, expOwn, expM, expC);
    end
  endtask

  task automatic drive(input logic mE, input logic [1:0] mD,
                       input logic cE, input logic [1:0] cD);
    mstWrEn = mE; mstWrData = mD; ctlWrEn = cE; ctlWrData = cD;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: run hung, actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    check("R1 reset state", 2'b00, 2'd0, 1'b0, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", 2'b00, 2'd0, 1'b0, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      logic [15:0] v;
      v = VEC[i];
      drive(v[15], v[14:13], v[12], v[11:10]);
      @(negedge clk);
      drive(1'b0, 2'b00, 1'b0, 2'b00);
      check($sformatf("R%0d R10 vector %0d", v[3:0], i), v[9:8], v[7:6], v[5], v[4]);
    end

    // R1: reset while control holds the lock
    rstN = 1'b0;
    @(negedge clk);
    check("R1 reset while held", 2'b00, 2'd0, 1'b0, 1'b0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 after reset, then R4 master re-claim while holding
    drive(1'b1, 2'b10, 1'b0, 2'b00);
    @(negedge clk);
    check("R2 claim after reset", 2'b10, 2'd1, 1'b0, 1'b0);
    drive(1'b1, 2'b10, 1'b0, 2'b00);
    @(negedge clk);
    check("R4 re-claim by holder refused", 2'b10, 2'd1, 1'b1, 1'b0);
    drive(1'b1, 2'b10, 1'b0, 2'b00);
    @(negedge clk);
    check("R9 back-to-back refusal", 2'b10, 2'd1, 1'b1, 1'b0);
    drive(1'b0, 2'b00, 1'b0, 2'b00);
    @(negedge clk);
    check("R9 strobe drops", 2'b10, 2'd1, 1'b0, 1'b0);

    // R7: write enable low with claim data has no effect
    drive(1'b0, 2'b00, 1'b0, 2'b01);
    @(negedge clk);
    check("R7 disabled write", 2'b10, 2'd1, 1'b0, 1'b0);

    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule